// File: doc/BRIEF.md
# Handshaked I/Q Sample Output Port

This block hands complex baseband samples from one receive channel to an external processor over a 16-bit parallel bus. For each sample it raises a request line and waits for the processor's acknowledge. It then sends the in-phase word, then the quadrature word, and, if the sample asks for it, a gain word. Each word carries sideband flags that mark the I word and the gain word. A channel field shows which channel the sample belongs to.

Words advance only on port clock ticks. In master mode the block makes these ticks itself by dividing the core clock by a programmable integer. In slave mode it takes them from the rising edges of an external port clock, which it samples in the core clock domain. That external clock is assumed to be synchronous and no faster than half the core rate. The block holds one sample in flight and one sample waiting. If a sample arrives when both places are taken, the block drops it and pulses an overflow flag.

Top module: `iq_port_tx`

## Requirements
- R1: While reset is held and right after it, `req`, `pdata`, `pch`, `piq`, `pgain` and `overflow` are all zero.
- R2: A sample accepted on `smp_valid` causes `req` to rise on a later port tick.
- R3: While `req` is high and the port is waiting, `pdata` stays zero and no flag is set until `ack` has been seen high on a port tick. If `ack` is already high when `req` rises, the I word appears exactly one port tick after `req` rises.
- R4: The I word is driven first, with `piq`=1. The Q word follows on the next port tick, with `piq`=0. During each word, `pch` equals the sample's channel number.
- R5: When `smp_gain_en` was 1, a third word follows Q on the next tick. It carries the 12-bit gain in `pdata[11:0]` with zeros above, and `pgain`=1. When `smp_gain_en` was 0, no gain word is sent. `piq` and `pgain` are never high together.
- R6: On the port tick after the last word, `req` falls and `pdata`, `pch`, `piq` and `pgain` return to zero.
- R7: A sample that arrives while a transfer is in progress is kept in a one-entry buffer. It is sent as the next transfer, with its own values intact.
- R8: A sample that arrives while both the active slot and the buffer are occupied is dropped. `overflow` is then high for exactly one core cycle, and the dropped sample is never sent.
- R9: In master mode (`slave_mode`=0), one port tick occurs every `clk_div` core cycles. A `clk_div` of 0 behaves as 1.
- R10: In slave mode (`slave_mode`=1), one port tick follows each rising edge of `ext_pclk`, and `clk_div` is ignored. While `ext_pclk` does not toggle, the port does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: ticks from `ext_pclk`; 0: ticks from the core clock divider |
| clk_div | input | DIV_W | Master-mode divisor (0 treated as 1) |
| ext_pclk | input | 1 | External port clock for slave mode |
| port_tick | output | 1 | One-core-cycle strobe that marks each port clock |
| smp_valid | input | 1 | New sample strobe |
| smp_i | input | DATA_W | In-phase word |
| smp_q | input | DATA_W | Quadrature word |
| smp_gain | input | GAIN_W | Gain word |
| smp_gain_en | input | 1 | Append the gain word to this sample's transfer |
| smp_ch | input | CH_W | Channel number of the sample |
| ack | input | 1 | Receiver acknowledge |
| req | output | 1 | Transfer request |
| pdata | output | DATA_W | Parallel data bus |
| pch | output | CH_W | Channel indicator |
| piq | output | 1 | High during the I word |
| pgain | output | 1 | High during the gain word |
| overflow | output | 1 | One-cycle pulse when a sample is dropped |

## Verification
The bench builds the block with a 16-bit bus, a 12-bit gain, a 3-bit channel field and a 4-bit divisor. With these values it can drive divisors of 3, 1 and 0, so it covers a tick on every core cycle, the zero-divisor case and a multi-cycle word period. It also drives a 4-cycle external port clock in slave mode. The short divisors let back-to-back arrivals fill both storage slots before any transfer finishes, which is what makes the overflow path reachable. Acknowledges arriving before and after the request cover both entries into the word sequence.

// File: rtl/iq_port_tx.sv
module iq_port_tx #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12,
  parameter int CH_W   = 3,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              ext_pclk,
  output logic              port_tick,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] smp_q,
  input  logic [GAIN_W-1:0] smp_gain,
  input  logic              smp_gain_en,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic              ack,
  output logic              req,
  output logic [DATA_W-1:0] pdata,
  output logic [CH_W-1:0]   pch,
  output logic              piq,
  output logic              pgain,
  output logic              overflow
);
  localparam int SLOT_W = 2*DATA_W + GAIN_W + 1 + CH_W;
  localparam int CH_LO  = 0;
  localparam int GE_B   = CH_W;
  localparam int G_LO   = CH_W + 1;
  localparam int Q_LO   = G_LO + GAIN_W;
  localparam int I_LO   = Q_LO + DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_I, S_Q, S_G} state_t;
  state_t st;

  logic [DIV_W-1:0]  cnt;
  logic              ext_q;
  logic [SLOT_W-1:0] cur, held, incoming;
  logic              cur_v, held_v;

  wire [DIV_W-1:0] div_m1  = (clk_div == '0) ? '0 : clk_div - 1'b1;
  wire             m_tick  = (cnt >= div_m1);
  assign port_tick = slave_mode ? (ext_pclk & ~ext_q) : m_tick;

  assign incoming = {smp_i, smp_q, smp_gain, smp_gain_en, smp_ch};

  wire cur_ge = cur[GE_B];
  wire fin    = port_tick && ((st == S_Q && !cur_ge) || st == S_G);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt   <= m_tick ? '0 : cnt + 1'b1;
      ext_q <= ext_pclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      held     <= '0;
      cur_v    <= 1'b0;
      held_v   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (fin) begin
        if (held_v) begin
          cur <= held;
          if (smp_valid) held <= incoming;
          else held_v <= 1'b0;
        end else if (smp_valid) begin
          cur <= incoming;
        end else begin
          cur_v <= 1'b0;
        end
      end else if (smp_valid) begin
        if (!cur_v) begin
          cur   <= incoming;
          cur_v <= 1'b1;
        end else if (!held_v) begin
          held   <= incoming;
          held_v <= 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      req   <= 1'b0;
      pdata <= '0;
      pch   <= '0;
      piq   <= 1'b0;
      pgain <= 1'b0;
    end else if (fin) begin
      st    <= S_IDLE;
      req   <= 1'b0;
      pdata <= '0;
      pch   <= '0;
      piq   <= 1'b0;
      pgain <= 1'b0;
    end else if (port_tick) begin
      case (st)
        S_IDLE: if (cur_v) begin
          req <= 1'b1;
          st  <= S_REQ;
        end
        S_REQ: if (ack) begin
          pdata <= cur[I_LO +: DATA_W];
          pch   <= cur[CH_LO +: CH_W];
          piq   <= 1'b1;
          st    <= S_I;
        end
        S_I: begin
          pdata <= cur[Q_LO +: DATA_W];
          piq   <= 1'b0;
          st    <= S_Q;
        end
        S_Q: begin
          pdata <= {{(DATA_W-GAIN_W){1'b0}}, cur[G_LO +: GAIN_W]};
          pgain <= 1'b1;
          st    <= S_G;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (pdata == '0 && !piq && !pgain));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(piq && pgain));

  assert_q_after_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_tick && piq) |=> (!piq && req));

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_tick |=> ($stable(pdata) && $stable(req) && $stable(piq)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(smp_valid));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !piq && !pgain && pdata == '0 && !port_tick) |=> req);
endmodule

// File: tb/iq_port_tx_test.sv
`timescale 1ns/1ps
module iq_port_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 1'b0;
  logic [3:0]  clk_div = 4'd3;
  logic        ext_pclk = 1'b0;
  logic        port_tick;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic [11:0] smp_gain = '0;
  logic        smp_gain_en = 1'b0;
  logic [2:0]  smp_ch = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [15:0] pdata;
  logic [2:0]  pch;
  logic        piq, pgain, overflow;

  int checks = 0;
  int fails  = 0;
  logic ext_run = 1'b0;
  logic [1:0] ext_cnt = '0;

  always #2 clk = ~clk;

  iq_port_tx #(.DATA_W(16), .GAIN_W(12), .CH_W(3), .DIV_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .clk_div(clk_div),
    .ext_pclk(ext_pclk), .port_tick(port_tick), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .smp_gain(smp_gain), .smp_gain_en(smp_gain_en),
    .smp_ch(smp_ch), .ack(ack), .req(req), .pdata(pdata), .pch(pch),
    .piq(piq), .pgain(pgain), .overflow(overflow));

  always @(negedge clk) if (ext_run) begin
    ext_cnt  = ext_cnt + 2'd1;
    ext_pclk = ext_cnt[1];
  end

  localparam logic [47:0] VEC [0:5] = '{
    48'h1234_ABCD_5A6_F, 48'h8000_7FFF_000_2, 48'hFFFF_0001_FFF_9,
    48'h0000_0000_123_0, 48'h5555_AAAA_ABC_C, 48'hC3C3_3C3C_777_6 };

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] v, output logic ov);
    @(negedge clk);
    {smp_i, smp_q, smp_gain, smp_gain_en, smp_ch} = v;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    ov = overflow;
  endtask

  task automatic xfer(input logic [47:0] v, input int per, input bit ackpre);
    logic [15:0] ei, eq;
    logic [11:0] eg;
    logic        ege;
    logic [2:0]  ech;
    int n;
    {ei, eq, eg, ege, ech} = v;
    ack = ackpre;
    n = 0;
    while (!req && n < 200) begin @(negedge clk); n++; end
    chk(req == 1'b1, "R2 req rise", {31'b0, req}, 1);
    if (ackpre) begin
      repeat (per) @(negedge clk);
      chk(piq == 1'b1, "R3 I word one tick after req", {31'b0, piq}, 1);
    end else begin
      repeat (2*per) @(negedge clk);
      chk(req && !piq && !pgain && pdata == 16'h0, "R3 quiet before ack",
          {req, piq, pgain, pdata}, {3'b100, 16'h0});
      ack = 1'b1;
      n = 0;
      while (!piq && n < 4*per) begin @(negedge clk); n++; end
    end
    chk(pdata == ei, "R4 I word", pdata, ei);
    chk(pch == ech && piq, "R4 I channel/flag", {piq, pch}, {1'b1, ech});
    repeat (per) @(negedge clk);
    chk(pdata == eq, "R4 Q word", pdata, eq);
    chk(pch == ech && !piq && !pgain, "R4 Q channel/flags", {piq, pgain, pch}, {2'b00, ech});
    if (ege) begin
      repeat (per) @(negedge clk);
      chk(pdata == {4'h0, eg} && pgain && !piq, "R5 gain word",
          {piq, pgain, pdata}, {2'b01, 4'h0, eg});
    end
    repeat (per) @(negedge clk);
    chk(!req && pdata == 16'h0 && !pgain && !piq && pch == 3'd0, "R6 end of transfer",
        {req, piq, pgain, pch, pdata}, 0);
    ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic ov;
    repeat (3) @(negedge clk);
    chk(!req && pdata == 0 && pch == 0 && !piq && !pgain && !overflow, "R1 reset state",
        {req, piq, pgain, overflow, pch, pdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && pdata == 0 && !overflow, "R1 after reset", {req, overflow, pdata}, 0);

    for (int k = 0; k < 6; k++) begin
      send(VEC[k], ov);
      xfer(VEC[k], 3, k[0]);
    end

    send(VEC[0], ov);
    send(VEC[1], ov);
    chk(ov == 1'b0, "R7 buffered no overflow", {31'b0, ov}, 0);
    xfer(VEC[0], 3, 1'b1);
    xfer(VEC[1], 3, 1'b1);

    send(VEC[2], ov);
    send(VEC[3], ov);
    send(VEC[4], ov);
    chk(ov == 1'b1, "R8 overflow pulse", {31'b0, ov}, 1);
    @(negedge clk);
    chk(overflow == 1'b0, "R8 pulse one cycle", {31'b0, overflow}, 0);
    xfer(VEC[2], 3, 1'b1);
    xfer(VEC[3], 3, 1'b1);
    repeat (40) @(negedge clk);
    chk(req == 1'b0, "R8 dropped sample not sent", {31'b0, req}, 0);

    clk_div = 4'd1;
    send(VEC[4], ov);
    xfer(VEC[4], 1, 1'b1);
    clk_div = 4'd0;
    send(VEC[5], ov);
    xfer(VEC[5], 1, 1'b1);
    send(VEC[2], ov);
    xfer(VEC[2], 1, 1'b0);
    chk(1'b1, "R9 divisors 1 and 0 run", 0, 0);

    clk_div = 4'd3;
    slave_mode = 1'b1;
    send(VEC[0], ov);
    repeat (20) @(negedge clk);
    chk(req == 1'b0, "R10 no advance without ext clock", {31'b0, req}, 0);
    ext_run = 1'b1;
    xfer(VEC[0], 4, 1'b1);
    send(VEC[4], ov);
    xfer(VEC[4], 4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule